// File: doc/BRIEF.md
# Floating-point constant push unit

This block carries out the seven load-constant operations of a stack-organised floating-point unit. It accepts a two-byte opcode and picks one of seven built-in constants. Each constant is kept as a 66-bit significand, meaning 64 result bits, a round bit and a sticky bit, together with a biased exponent. The unit rounds the chosen constant to an 80-bit extended-precision value under the current rounding-control setting. It then moves the stack top pointer down by one and writes the rounded value into the register that has just become the top of the stack.

The unit owns an eight-entry register stack with a two-bit tag per entry, the 3-bit top pointer, the C1 condition bit, the sticky invalid-operation and stack-fault flags, and three fault pulses. The faults report a locked instruction, a device that is not available, and a pending floating-point error. A read port lets the surrounding core look at any physical register and its tag.

The core presents an instruction with a one-cycle `issue_valid` strobe. All results, including the `done` pulse and any fault pulse, appear on the clock edge that samples the strobe.

Top module: `fpconst_push_unit`

## Requirements
- R1: An instruction is carried out only when `issue_valid` is high, `opc_hi` is D9h and `opc_lo` lies in E8h..EEh. Any other opcode leaves the top pointer, registers, tags and flags unchanged and gives no pulse.
- R2: Reset sets the top pointer to 0, sets every tag to empty (11) and clears C1 and both flags. A push first computes the new top as (top − 1) mod 8 and then writes the new top register.
- R3: With rounding control 00 (nearest, ties to even), the second opcode bytes E8h..EEh give these 80-bit results in order: 3FFF_8000000000000000, 4000_D49A784BCD1B8AFE, 3FFF_B8AA3B295C17F0BC, 4000_C90FDAA22168C235, 3FFD_9A209A84FBCFF799, 3FFE_B17217F7D1CF79AC and all-zero. Each result is written as sign, 15-bit exponent and 64-bit significand, with the sign 0.
- R4: Rounding control 01 (toward minus infinity) and 11 (toward zero) truncate the significand. Rounding control 10 (toward plus infinity) adds one when the round or sticky bit is set. A carry out of the significand shifts the significand right by one and adds one to the exponent.
- R5: +1.0 and +0.0 are exact under every rounding mode. A written +0.0 gets tag 01, and every other constant gets tag 00 (valid).
- R6: A load that does not overflow leaves C1 at 0, even when the value was rounded up. No precision flag exists, and rounding never signals inexactness.
- R7: Stack overflow occurs when the tag of the new top register is not 11. On overflow, C1, the invalid flag and the stack flag are set, and both flags stay set until reset. If `inv_mask` is 1, the top pointer moves and the register gets the indefinite value 1_7FFF_C000000000000000 with tag 10. If `inv_mask` is 0, the top pointer and all registers stay unchanged.
- R8: `lock_prefix` on a decoded instruction gives `fault_badop` and changes no state.
- R9: If `cr_emulate` or `cr_task_sw` is set, and no lock fault applies, the unit gives `fault_nodev` and changes no state.
- R10: If `fp_pending` is set and no higher fault applies, the unit gives `fault_fperr` and changes no state. The priority order is lock, then no-device, then pending error.
- R11: `done` pulses for one cycle for each decoded instruction that raises no fault, including an overflowing one. For each instruction, at most one of `done` and the three fault pulses is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction strobe |
| opc_hi | input | 8 | First opcode byte |
| opc_lo | input | 8 | Second opcode byte |
| lock_prefix | input | 1 | Instruction carries a lock prefix |
| cr_emulate | input | 1 | Emulation control bit |
| cr_task_sw | input | 1 | Task-switched control bit |
| fp_pending | input | 1 | Unmasked floating-point exception pending |
| rc_mode | input | 2 | Rounding control |
| inv_mask | input | 1 | Invalid-operation mask |
| rd_idx | input | 3 | Physical register to read |
| rd_value | output | 80 | Value of register `rd_idx` |
| rd_tag | output | 2 | Tag of register `rd_idx` |
| top_ptr | output | 3 | Stack top pointer |
| c1_flag | output | 1 | C1 condition bit |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_stack | output | 1 | Sticky stack-fault flag |
| done | output | 1 | Instruction completed |
| fault_badop | output | 1 | Invalid-opcode fault (lock) |
| fault_nodev | output | 1 | Device-not-available fault |
| fault_fperr | output | 1 | Floating-point error fault |

## Verification
The bench builds the unit with its default parameters: eight stack entries, a 15-bit exponent, a 64-bit significand and two guard bits. With eight entries, nine pushes after a reset are enough to reach overflow, so both masked and unmasked overflow, and wrap of the pointer from 0 to 7, happen many times in a short run. The two guard bits cover every round and sticky combination that the constant table contains, which puts round-half-even and directed rounding within reach for each constant.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   localparam int KEXP_W = 15;
   localparam int KSIG_W = 66;

   typedef enum logic [1:0] {
      TAG_VALID   = 2'b00,
      TAG_ZERO    = 2'b01,
      TAG_SPECIAL = 2'b10,
      TAG_EMPTY   = 2'b11
   } tag_t;

   typedef enum logic [1:0] {
      RND_NEAR = 2'b00,
      RND_DOWN = 2'b01,
      RND_UP   = 2'b10,
      RND_TRUNC = 2'b11
   } rnd_t;

   typedef enum logic [2:0] {
      K_ONE  = 3'd0,
      K_L2T  = 3'd1,
      K_L2E  = 3'd2,
      K_PI   = 3'd3,
      K_LG2  = 3'd4,
      K_LN2  = 3'd5,
      K_ZERO = 3'd6,
      K_NONE = 3'd7
   } kid_t;
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
   import fpc_pkg::*;
#(
   parameter logic [7:0] ESC_BYTE  = 8'hD9,
   parameter logic [7:0] BASE_BYTE = 8'hE8,
   parameter int         NUM_K     = 7
) (
   input  logic [7:0] hi,
   input  logic [7:0] lo,
   output logic       hit,
   output kid_t       kid
);
   logic [7:0] off;

   always_comb begin
      off = lo - BASE_BYTE;
      hit = (hi == ESC_BYTE) && (off < 8'(NUM_K));
      kid = hit ? kid_t'(off[2:0]) : K_NONE;
   end
endmodule

// File: rtl/fpc_const_rom.sv
module fpc_const_rom
   import fpc_pkg::*;
(
   input  kid_t              kid,
   output logic [KEXP_W-1:0] k_exp,
   output logic [KSIG_W-1:0] k_sig
);
   // significand = 64 result bits, then round bit, then sticky bit
   always_comb begin
      unique case (kid)
         K_ONE:   begin k_exp = 15'h3FFF; k_sig = {64'h8000000000000000, 2'b00}; end
         K_L2T:   begin k_exp = 15'h4000; k_sig = {64'hD49A784BCD1B8AFE, 2'b01}; end
         K_L2E:   begin k_exp = 15'h3FFF; k_sig = {64'hB8AA3B295C17F0BB, 2'b11}; end
         K_PI:    begin k_exp = 15'h4000; k_sig = {64'hC90FDAA22168C234, 2'b11}; end
         K_LG2:   begin k_exp = 15'h3FFD; k_sig = {64'h9A209A84FBCFF798, 2'b11}; end
         K_LN2:   begin k_exp = 15'h3FFE; k_sig = {64'hB17217F7D1CF79AB, 2'b11}; end
         default: begin k_exp = '0;       k_sig = '0; end
      endcase
   end
endmodule

// File: rtl/fpc_round.sv
module fpc_round #(
   parameter int SIG_W = 64,
   parameter int GRD_W = 2,
   parameter int EXP_W = 15
) (
   input  logic [EXP_W-1:0]       exp_i,
   input  logic [SIG_W+GRD_W-1:0] sig_i,
   input  logic [1:0]             rc,
   output logic [EXP_W-1:0]       exp_o,
   output logic [SIG_W-1:0]       sig_o
);
   logic             lsb, rbit, sbit, inc;
   logic [SIG_W:0]   sum;

   assign lsb  = sig_i[GRD_W];
   assign rbit = sig_i[GRD_W-1];

   generate
      if (GRD_W > 1) begin : g_sticky
         assign sbit = |sig_i[GRD_W-2:0];
      end else begin : g_nosticky
         assign sbit = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (rc)
         2'b00:   inc = rbit & (sbit | lsb);
         2'b10:   inc = rbit | sbit;
         default: inc = 1'b0;
      endcase
      sum = {1'b0, sig_i[SIG_W+GRD_W-1:GRD_W]} + (SIG_W+1)'(inc);
      if (sum[SIG_W]) begin
         sig_o = sum[SIG_W:1];
         exp_o = exp_i + 1'b1;
      end else begin
         sig_o = sum[SIG_W-1:0];
         exp_o = exp_i;
      end
   end
endmodule

// File: rtl/fpc_stack.sv
module fpc_stack #(
   parameter int DEPTH = 8,
   parameter int VAL_W = 80,
   parameter int TOP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TOP_W-1:0] wr_idx,
   input  logic [VAL_W-1:0] wr_val,
   input  logic [1:0]       wr_tag,
   input  logic [TOP_W-1:0] rd_idx,
   output logic [VAL_W-1:0] rd_val,
   output logic [1:0]       rd_tag,
   input  logic [TOP_W-1:0] chk_idx,
   output logic [1:0]       chk_tag
);
   logic [VAL_W-1:0] val_q [DEPTH];
   logic [1:0]       tag_q [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               val_q[g] <= '0;
               tag_q[g] <= 2'b11;
            end else if (wr_en && wr_idx == TOP_W'(g)) begin
               val_q[g] <= wr_val;
               tag_q[g] <= wr_tag;
            end
         end
      end
   endgenerate

   assign rd_val  = val_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
   assign chk_tag = tag_q[chk_idx];
endmodule

// File: rtl/fpconst_push_unit.sv
module fpconst_push_unit
   import fpc_pkg::*;
#(
   parameter int         DEPTH     = 8,
   parameter int         EXP_W     = 15,
   parameter int         SIG_W     = 64,
   parameter int         GRD_W     = 2,
   parameter logic [7:0] ESC_BYTE  = 8'hD9,
   parameter logic [7:0] BASE_BYTE = 8'hE8,
   localparam int        TOP_W     = $clog2(DEPTH),
   localparam int        VAL_W     = 1 + EXP_W + SIG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_valid,
   input  logic [7:0]       opc_hi,
   input  logic [7:0]       opc_lo,
   input  logic             lock_prefix,
   input  logic             cr_emulate,
   input  logic             cr_task_sw,
   input  logic             fp_pending,
   input  logic [1:0]       rc_mode,
   input  logic             inv_mask,
   input  logic [TOP_W-1:0] rd_idx,
   output logic [VAL_W-1:0] rd_value,
   output logic [1:0]       rd_tag,
   output logic [TOP_W-1:0] top_ptr,
   output logic             c1_flag,
   output logic             flag_invalid,
   output logic             flag_stack,
   output logic             done,
   output logic             fault_badop,
   output logic             fault_nodev,
   output logic             fault_fperr
);
   localparam int NUM_K = 7;
   localparam logic [VAL_W-1:0] QNAN_IND =
      {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

   // elaboration-time parameter checks
   if (DEPTH != (1 << TOP_W) || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (EXP_W != KEXP_W || SIG_W + GRD_W != KSIG_W) begin : g_bad_fmt
      $error("format widths must match the constant table");
   end
   if (GRD_W < 1) begin : g_bad_grd
      $error("at least one guard bit is required");
   end

   logic             hit;
   kid_t             kid;
   logic [EXP_W-1:0] k_exp, r_exp;
   logic [KSIG_W-1:0] k_sig;
   logic [SIG_W-1:0] r_sig;
   logic [1:0]       chk_tag;
   logic [TOP_W-1:0] top_q, new_top;
   logic             go, ud, nm, mf, exec, ovf, wr_en;
   logic [VAL_W-1:0] wr_val;
   tag_t             wr_tag;
   logic             c1_q, ie_q, sf_q, done_q, ud_q, nm_q, mf_q;

   fpc_decode #(.ESC_BYTE(ESC_BYTE), .BASE_BYTE(BASE_BYTE), .NUM_K(NUM_K)) u_dec (
      .hi(opc_hi), .lo(opc_lo), .hit(hit), .kid(kid));

   fpc_const_rom u_rom (.kid(kid), .k_exp(k_exp), .k_sig(k_sig));

   fpc_round #(.SIG_W(SIG_W), .GRD_W(GRD_W), .EXP_W(EXP_W)) u_rnd (
      .exp_i(k_exp), .sig_i(k_sig), .rc(rc_mode), .exp_o(r_exp), .sig_o(r_sig));

   always_comb begin
      new_top = top_q - 1'b1;
      go      = issue_valid & hit;
      ud      = go & lock_prefix;
      nm      = go & ~lock_prefix & (cr_emulate | cr_task_sw);
      mf      = go & ~lock_prefix & ~cr_emulate & ~cr_task_sw & fp_pending;
      exec    = go & ~lock_prefix & ~cr_emulate & ~cr_task_sw & ~fp_pending;
      ovf     = exec & (tag_t'(chk_tag) != TAG_EMPTY);
      wr_en   = exec & (~ovf | inv_mask);
      if (ovf) begin
         wr_val = QNAN_IND;
         wr_tag = TAG_SPECIAL;
      end else begin
         wr_val = {1'b0, r_exp, r_sig};
         wr_tag = (kid == K_ZERO) ? TAG_ZERO : TAG_VALID;
      end
   end

   fpc_stack #(.DEPTH(DEPTH), .VAL_W(VAL_W), .TOP_W(TOP_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(new_top),
      .wr_val(wr_val), .wr_tag(wr_tag), .rd_idx(rd_idx), .rd_val(rd_value),
      .rd_tag(rd_tag), .chk_idx(new_top), .chk_tag(chk_tag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q  <= '0;
         c1_q   <= 1'b0;
         ie_q   <= 1'b0;
         sf_q   <= 1'b0;
         done_q <= 1'b0;
         ud_q   <= 1'b0;
         nm_q   <= 1'b0;
         mf_q   <= 1'b0;
      end else begin
         done_q <= exec;
         ud_q   <= ud;
         nm_q   <= nm;
         mf_q   <= mf;
         if (exec) c1_q <= ovf;
         if (ovf) begin
            ie_q <= 1'b1;
            sf_q <= 1'b1;
         end
         if (wr_en) top_q <= new_top;
      end
   end

   assign top_ptr      = top_q;
   assign c1_flag      = c1_q;
   assign flag_invalid = ie_q;
   assign flag_stack   = sf_q;
   assign done         = done_q;
   assign fault_badop  = ud_q;
   assign fault_nodev  = nm_q;
   assign fault_fperr  = mf_q;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
   parameter int         TOP_W     = 3,
   parameter logic [7:0] ESC_BYTE  = 8'hD9,
   parameter logic [7:0] BASE_BYTE = 8'hE8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             issue_valid,
   input logic [7:0]       opc_hi,
   input logic [7:0]       opc_lo,
   input logic             lock_prefix,
   input logic             cr_emulate,
   input logic             cr_task_sw,
   input logic             fp_pending,
   input logic [TOP_W-1:0] top_ptr,
   input logic             c1_flag,
   input logic             flag_invalid,
   input logic             flag_stack,
   input logic             done,
   input logic             fault_badop,
   input logic             fault_nodev,
   input logic             fault_fperr
);
   logic [7:0] off;
   logic       dec;
   assign off = opc_lo - BASE_BYTE;
   assign dec = issue_valid && opc_hi == ESC_BYTE && off < 8'd7;

   a_r2_top_step: assert property (@(posedge clk) disable iff (!rst_n)
      done && !c1_flag |-> top_ptr == TOP_W'($past(top_ptr) - 1'b1));

   a_r6_c1_only_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      done && c1_flag |-> flag_stack && flag_invalid);

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag_stack |=> flag_stack);

   a_r8_badop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dec && lock_prefix |=> fault_badop && $stable(top_ptr));

   a_r9_nodev: assert property (@(posedge clk) disable iff (!rst_n)
      dec && !lock_prefix && (cr_emulate || cr_task_sw) |=> fault_nodev && $stable(top_ptr));

   a_r10_fperr: assert property (@(posedge clk) disable iff (!rst_n)
      dec && !lock_prefix && !cr_emulate && !cr_task_sw && fp_pending
      |=> fault_fperr && $stable(top_ptr));

   a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, fault_badop, fault_nodev, fault_fperr}));

   a_r1_no_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dec |=> !done && $stable(top_ptr));
endmodule

bind fpconst_push_unit fpc_checker #(
   .TOP_W(TOP_W), .ESC_BYTE(ESC_BYTE), .BASE_BYTE(BASE_BYTE)
) u_fpc_checker (
   .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opc_hi(opc_hi),
   .opc_lo(opc_lo), .lock_prefix(lock_prefix), .cr_emulate(cr_emulate),
   .cr_task_sw(cr_task_sw), .fp_pending(fp_pending), .top_ptr(top_ptr),
   .c1_flag(c1_flag), .flag_invalid(flag_invalid), .flag_stack(flag_stack),
   .done(done), .fault_badop(fault_badop), .fault_nodev(fault_nodev),
   .fault_fperr(fault_fperr));

// File: tb/test_fpconst_push_unit.sv
module test_fpconst_push_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [7:0]  opc_hi = '0, opc_lo = '0;
   logic        lock_prefix = 1'b0, cr_emulate = 1'b0, cr_task_sw = 1'b0, fp_pending = 1'b0;
   logic [1:0]  rc_mode = '0;
   logic        inv_mask = 1'b0;
   logic [2:0]  rd_idx = '0;
   logic [79:0] rd_value;
   logic [1:0]  rd_tag;
   logic [2:0]  top_ptr;
   logic        c1_flag, flag_invalid, flag_stack, done, fault_badop, fault_nodev, fault_fperr;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [79:0] m_val [8];
   logic [1:0]  m_tag [8];
   logic [2:0]  m_top;
   logic        m_c1, m_ie, m_sf;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpconst_push_unit i_fpconst_push_unit (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .opc_hi(opc_hi),
      .opc_lo(opc_lo), .lock_prefix(lock_prefix), .cr_emulate(cr_emulate),
      .cr_task_sw(cr_task_sw), .fp_pending(fp_pending), .rc_mode(rc_mode),
      .inv_mask(inv_mask), .rd_idx(rd_idx), .rd_value(rd_value), .rd_tag(rd_tag),
      .top_ptr(top_ptr), .c1_flag(c1_flag), .flag_invalid(flag_invalid),
      .flag_stack(flag_stack), .done(done), .fault_badop(fault_badop),
      .fault_nodev(fault_nodev), .fault_fperr(fault_fperr));

   task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   // expected constants from long prefixes: 64 result bits then 32 more bits
   function automatic logic [79:0] k_expect(int k, logic [1:0] rc);
      logic [95:0] pre;
      logic [14:0] e;
      logic        r, s, l, inc;
      logic [64:0] sg;
      case (k)
         0: return {1'b0, 15'h3FFF, 64'h8000000000000000};
         1: begin pre = 96'hD49A784BCD1B8AFE492BF6FF; e = 15'h4000; end
         2: begin pre = 96'hB8AA3B295C17F0BBBE87FED0; e = 15'h3FFF; end
         3: begin pre = 96'hC90FDAA22168C234C4C6628B; e = 15'h4000; end
         4: begin pre = 96'h9A209A84FBCFF7988F8959AC; e = 15'h3FFD; end
         5: begin pre = 96'hB17217F7D1CF79ABC9E3B398; e = 15'h3FFE; end
         default: return '0;
      endcase
      l = pre[32]; r = pre[31]; s = |pre[30:0];
      case (rc)
         2'b00:   inc = r & (s | l);
         2'b10:   inc = r | s;
         default: inc = 1'b0;
      endcase
      sg = {1'b0, pre[95:32]} + 65'(inc);
      if (sg[64]) begin sg = sg >> 1; e = e + 1'b1; end
      return {1'b0, e, sg[63:0]};
   endfunction

   task automatic check_slot(string req, logic [2:0] idx);
      rd_idx = idx;
      #1;
      chk(req, $sformatf("value[%0d]", idx), rd_value, m_val[idx]);
      chk(req, $sformatf("tag[%0d]", idx), 80'(rd_tag), 80'(m_tag[idx]));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_top = '0; m_c1 = 0; m_ie = 0; m_sf = 0;
      for (int i = 0; i < 8; i++) begin m_val[i] = '0; m_tag[i] = 2'b11; end
      chk("R2", "reset top", 80'(top_ptr), 80'(0));
      chk("R2", "reset c1/flags", 80'({c1_flag, flag_invalid, flag_stack}), 80'(0));
      for (int i = 0; i < 8; i++) begin
         rd_idx = 3'(i); #1;
         chk("R2", $sformatf("reset tag[%0d]", i), 80'(rd_tag), 80'(2'b11));
      end
   endtask

   // issue one instruction, update the model, compare everything visible
   task automatic do_op(string req, logic [7:0] hi, logic [7:0] lo, logic lk, logic em,
                        logic ts, logic pd, logic [1:0] rc, logic mk);
      logic hit;
      logic [3:0] exp_pulse;   // {done, badop, nodev, fperr}
      logic [2:0] nt;
      int k;
      hit = (hi == 8'hD9) && (lo >= 8'hE8) && (lo <= 8'hEE);
      k = int'(lo) - 'hE8;
      nt = m_top - 1'b1;
      exp_pulse = '0;
      if (hit) begin
         if (lk) exp_pulse = 4'b0100;
         else if (em || ts) exp_pulse = 4'b0010;
         else if (pd) exp_pulse = 4'b0001;
         else begin
            exp_pulse = 4'b1000;
            if (m_tag[nt] != 2'b11) begin
               m_c1 = 1; m_ie = 1; m_sf = 1;
               if (mk) begin
                  m_val[nt] = {1'b1, 15'h7FFF, 64'hC000000000000000};
                  m_tag[nt] = 2'b10;
                  m_top = nt;
               end
            end else begin
               m_c1 = 0;
               m_val[nt] = k_expect(k, rc);
               m_tag[nt] = (k == 6) ? 2'b01 : 2'b00;
               m_top = nt;
            end
         end
      end
      @(negedge clk);
      issue_valid = 1'b1; opc_hi = hi; opc_lo = lo; lock_prefix = lk;
      cr_emulate = em; cr_task_sw = ts; fp_pending = pd; rc_mode = rc; inv_mask = mk;
      @(negedge clk);
      issue_valid = 1'b0;
      chk(req, "pulses done/badop/nodev/fperr",
          80'({done, fault_badop, fault_nodev, fault_fperr}), 80'(exp_pulse));
      chk(req, "top", 80'(top_ptr), 80'(m_top));
      chk(req, "c1", 80'(c1_flag), 80'(m_c1));
      chk(req, "flags", 80'({flag_invalid, flag_stack}), 80'({m_ie, m_sf}));
      check_slot(req, m_top);
      check_slot(req, m_top - 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5EED_0A17;
      void'($urandom(seed));
      do_reset();

      // R3/R4/R5/R6: every constant under every rounding mode, from a clean stack
      for (int rc = 0; rc < 4; rc++) begin
         do_reset();
         for (int k = 0; k < 7; k++)
            do_op(rc == 0 ? "R3" : (k == 0 || k == 6) ? "R5" : "R4",
                  8'hD9, 8'(8'hE8 + k), 0, 0, 0, 0, 2'(rc), 0);
      end

      // R6: rounded-up value (pi toward plus infinity) leaves C1 at 0
      do_reset();
      do_op("R6", 8'hD9, 8'hEB, 0, 0, 0, 0, 2'b10, 0);

      // R1: opcodes outside the set are ignored
      do_op("R1", 8'hD9, 8'hEF, 0, 0, 0, 0, 2'b00, 0);
      do_op("R1", 8'hD9, 8'hE7, 0, 0, 0, 0, 2'b00, 0);
      do_op("R1", 8'hD8, 8'hE8, 0, 0, 0, 0, 2'b00, 0);

      // R8/R9/R10: faults and their order
      do_op("R8", 8'hD9, 8'hE8, 1, 1, 1, 1, 2'b00, 0);
      do_op("R9", 8'hD9, 8'hE9, 0, 1, 0, 1, 2'b00, 0);
      do_op("R9", 8'hD9, 8'hEA, 0, 0, 1, 0, 2'b00, 0);
      do_op("R10", 8'hD9, 8'hEB, 0, 0, 0, 1, 2'b00, 0);

      // R2/R7: fill the stack, then unmasked and masked overflow
      do_reset();
      for (int i = 0; i < 8; i++) do_op("R2", 8'hD9, 8'(8'hE8 + (i % 7)), 0, 0, 0, 0, 2'b00, 0);
      do_op("R7", 8'hD9, 8'hEB, 0, 0, 0, 0, 2'b00, 0);
      do_op("R7", 8'hD9, 8'hEB, 0, 0, 0, 0, 2'b00, 1);
      do_op("R11", 8'hD9, 8'hEC, 0, 0, 0, 0, 2'b01, 1);

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [7:0] lo;
         if ($urandom_range(0, 24) == 0) do_reset();
         lo = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(8'hE0, 8'hF7))
                                          : 8'(8'hE8 + $urandom_range(0, 6));
         do_op("R11", ($urandom_range(0, 19) == 0) ? 8'hDD : 8'hD9, lo,
               $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
               $urandom_range(0, 15) == 0, $urandom_range(0, 11) == 0,
               2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule